// File: doc/BRIEF.md
# Proportion-Statistic Automatic Gain Controller

This block closes the digital half of a receiver gain loop. The analog stage quantizes the input, and a flag per sample reports whether that sample's magnitude lies above a fixed threshold. With a two-level-magnitude converter the flag is the magnitude bit itself. With a wider converter it is the result of comparing the magnitude with the threshold outside this block. The input is dominated by Gaussian thermal noise. At the chosen threshold-to-sigma ratio, about one sample in three should have the flag set. The controller therefore counts flagged samples over fixed windows and compares the count with that target share.

At the close of each window, a count outside the lock band is turned into a gain correction in units of one code, which is 2 dB. The code spans 0 to 31, so the gain runs from -10 dB at code 0 to +52 dB at code 31. A count far from the target receives a coarse correction in proportion to the error. A count near the target receives a single-code refinement. Estimating the level from a proportion rather than from an average amplitude keeps the estimate valid for a coarse converter, and clipped samples need no compensation. A sudden level change after lock makes the loop leave lock and correct again straight away.

Top module: `agc_prop_top`

## Requirements
- R1: After reset, gainCode is 16, busy is 1 and locked is 0.
- R2: A window holds 1024 cycles in which sampleValid is 1. Only in those cycles is magBit counted. Cycles with sampleValid at 0 neither advance the window nor add to the count, whatever magBit is.
- R3: gainCode, busy and locked change only on the clock edge that accepts the 1024th valid sample of a window. The new values are visible from the following cycle.
- R4: If the window count C is within 338 ± 32 (306 to 370 inclusive), locked becomes 1 and busy becomes 0, and gainCode is unchanged.
- R5: If |C − 338| is from 33 to 128, gainCode moves by exactly one code. It falls when C > 338 and rises when C < 338.
- R6: If |C − 338| > 128, gainCode moves by min(floor(|C − 338| / 32), 8) codes, in the same direction as R5.
- R7: gainCode saturates at 0 and 31. Code k stands for a gain of −10 + 2k dB.
- R8: Any window outside the lock band clears locked and sets busy, and its correction is applied in that same update. This includes a window that follows a locked window, so an abrupt level change restarts the adjustment.
- R9: busy and locked are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | A new sample flag is present this cycle |
| magBit | input | 1 | Sample magnitude lies above the threshold |
| gainCode | output | 5 | Amplifier gain code, 2 dB per step |
| busy | output | 1 | Loop is adjusting |
| locked | output | 1 | Last window's count was inside the lock band |

## Verification
The assertions assume that sampleValid and magBit are stable around the rising edge. They also assume that magBit is meaningful only when sampleValid is 1, because the counter relations they check depend on the window advancing only on valid cycles. The stimulus changes both inputs only at the falling edge. It places the flagged samples of each window first and then holds magBit low. Where it inserts idle cycles, it drives magBit high during them to show that the flag is ignored there. Window counts are chosen at the edges of the lock, fine and coarse bands and at the saturation limits of the gain code.

// File: rtl/agc_pkg.sv
package agc_pkg;
  // Strobes from the lock controller to the statistics datapath
  typedef struct packed {
    logic apply;   // update the gain code this cycle
    logic coarse;  // use the proportional correction instead of one code
  } agcCtl_t;
endpackage

// File: rtl/agc_stat_path.sv
module agc_stat_path
  import agc_pkg::*;
#(
  parameter int WIN_LEN    = 1024,
  parameter int TARGET     = 338,
  parameter int LOCK_TOL   = 32,
  parameter int BIG_TOL    = 128,
  parameter int MAX_COARSE = 8,
  parameter int GAIN_W     = 5,
  parameter int INIT_GAIN  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              magBit,
  input  agcCtl_t           ctl,
  output logic              winEnd,
  output logic              inBand,
  output logic              bigErr,
  output logic [GAIN_W-1:0] gainCode
);
  localparam int CNT_W      = $clog2(WIN_LEN + 1);
  localparam int ERR_W      = CNT_W + 1;
  localparam int STEP_SHIFT = $clog2(LOCK_TOL);
  localparam int GAIN_MAX   = (1 << GAIN_W) - 1;
  localparam int SUM_W      = GAIN_W + 3;

  logic [CNT_W-1:0]        sampCnt, highCnt, fullCnt;
  logic signed [ERR_W-1:0] err;
  logic [ERR_W-1:0]        absErr, coarseMag;
  logic [GAIN_W+1:0]       stepMag;
  logic signed [SUM_W-1:0] gainSum;
  logic [GAIN_W-1:0]       gainQ, gainNext;

  // Window statistics: count the flagged samples among the valid ones
  assign fullCnt = highCnt + CNT_W'(magBit);
  assign winEnd  = sampleValid && (sampCnt == CNT_W'(WIN_LEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampCnt <= '0;
      highCnt <= '0;
    end else if (sampleValid) begin
      if (winEnd) begin
        sampCnt <= '0;
        highCnt <= '0;
      end else begin
        sampCnt <= sampCnt + CNT_W'(1);
        highCnt <= fullCnt;
      end
    end
  end

  // Error against the target share and its correction size
  always_comb begin
    err       = $signed({1'b0, fullCnt}) - $signed(ERR_W'(TARGET));
    absErr    = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
    inBand    = absErr <= ERR_W'(LOCK_TOL);
    bigErr    = absErr > ERR_W'(BIG_TOL);
    coarseMag = absErr >> STEP_SHIFT;
    if (ctl.coarse)
      stepMag = (coarseMag > ERR_W'(MAX_COARSE)) ? (GAIN_W+2)'(MAX_COARSE)
                                                 : coarseMag[GAIN_W+1:0];
    else
      stepMag = (GAIN_W+2)'(1);
    if (err > 0)
      gainSum = $signed({3'b000, gainQ}) - $signed({1'b0, stepMag});
    else
      gainSum = $signed({3'b000, gainQ}) + $signed({1'b0, stepMag});
    if (gainSum < 0)
      gainNext = '0;
    else if (gainSum > SUM_W'(GAIN_MAX))
      gainNext = GAIN_W'(GAIN_MAX);
    else
      gainNext = gainSum[GAIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          gainQ <= GAIN_W'(INIT_GAIN);
    else if (ctl.apply) gainQ <= gainNext;
  end

  assign gainCode = gainQ;

  // R2: the flagged tally never runs ahead of the sample tally
  a_r2_high_le_samp: assert property (@(posedge clk) disable iff (!rstN)
    highCnt <= sampCnt);
  // R2: idle cycles do not advance the window
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(sampCnt) && $stable(highCnt));
  // R3: the gain moves only when the controller strobes an update
  a_r3_gain_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.apply |=> $stable(gainCode));
  // R5: a fine update moves the gain by at most one code
  a_r5_fine_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.apply && !ctl.coarse) |=>
      ({1'b0, gainCode} == {1'b0, $past(gainCode)} + 1'b1) ||
      ({1'b0, gainCode} + 1'b1 == {1'b0, $past(gainCode)}) ||
      $stable(gainCode));
  // R6: no update moves the gain by more than the coarse limit
  a_r6_coarse_bound: assert property (@(posedge clk) disable iff (!rstN)
    ctl.apply |=>
      ((int'(gainCode) - int'($past(gainCode))) <= MAX_COARSE) &&
      ((int'($past(gainCode)) - int'(gainCode)) <= MAX_COARSE));
endmodule

// File: rtl/agc_lock_ctrl.sv
module agc_lock_ctrl
  import agc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    winEnd,
  input  logic    inBand,
  input  logic    bigErr,
  output agcCtl_t ctl,
  output logic    busy,
  output logic    locked
);
  // At each window close, a count outside the band always triggers a correction
  always_comb begin
    ctl.apply  = winEnd && !inBand;
    ctl.coarse = bigErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked <= 1'b0;
      busy   <= 1'b1;
    end else if (winEnd) begin
      locked <= inBand;
      busy   <= !inBand;
    end
  end

  // R3: the status flags change only at a window close
  a_r3_lock_hold: assert property (@(posedge clk) disable iff (!rstN)
    !winEnd |=> $stable(locked) && $stable(busy));
  // R8: a correction out of lock drops lock and raises busy
  a_r8_restart: assert property (@(posedge clk) disable iff (!rstN)
    ctl.apply |=> !locked && busy);
  // R9: adjusting and locked are exclusive
  a_r9_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && locked));
endmodule

// File: rtl/agc_prop_top.sv
module agc_prop_top
  import agc_pkg::*;
#(
  parameter int WIN_LEN    = 1024,
  parameter int TARGET     = 338,
  parameter int LOCK_TOL   = 32,
  parameter int BIG_TOL    = 128,
  parameter int MAX_COARSE = 8,
  parameter int GAIN_W     = 5,
  parameter int INIT_GAIN  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              magBit,
  output logic [GAIN_W-1:0] gainCode,
  output logic              busy,
  output logic              locked
);
  agcCtl_t ctl;
  logic    winEnd, inBand, bigErr;

  agc_stat_path #(
    .WIN_LEN(WIN_LEN), .TARGET(TARGET), .LOCK_TOL(LOCK_TOL),
    .BIG_TOL(BIG_TOL), .MAX_COARSE(MAX_COARSE), .GAIN_W(GAIN_W),
    .INIT_GAIN(INIT_GAIN)
  ) uPath (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .magBit(magBit),
    .ctl(ctl), .winEnd(winEnd), .inBand(inBand), .bigErr(bigErr),
    .gainCode(gainCode)
  );

  agc_lock_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .winEnd(winEnd), .inBand(inBand),
    .bigErr(bigErr), .ctl(ctl), .busy(busy), .locked(locked)
  );
endmodule

// File: tb/sim_agc_prop_top.sv
module sim_agc_prop_top;
  typedef struct {
    int    gain;
    bit    busy;
    bit    locked;
    string tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleValid = 1'b0;
  logic       magBit = 1'b0;
  logic [4:0] gainCode;
  logic       busy, locked;

  int checks = 0;
  int fails  = 0;
  int mGain  = 16;
  bit mBusy  = 1'b1;
  bit mLock  = 1'b0;
  bit finished = 1'b0;
  expItem_t expQ[$];
  event winTick;

  agc_prop_top u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .magBit(magBit),
    .gainCode(gainCode), .busy(busy), .locked(locked)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // Reference model built from the requirements
  task automatic modelWindow(input int cnt, input string tag);
    int e, a, m;
    expItem_t it;
    e = cnt - 338;
    a = (e < 0) ? -e : e;
    if (a <= 32) begin
      mLock = 1'b1; mBusy = 1'b0;
    end else begin
      if (a > 128) m = ((a / 32) > 8) ? 8 : (a / 32);
      else         m = 1;
      mGain = (e > 0) ? mGain - m : mGain + m;
      if (mGain < 0)  mGain = 0;
      if (mGain > 31) mGain = 31;
      mLock = 1'b0; mBusy = 1'b1;
    end
    it.gain = mGain; it.busy = mBusy; it.locked = mLock; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Driver: one window with cnt flagged samples, optional idle gaps
  task automatic runWindow(input int cnt, input bit gaps, input string tag);
    int holdGain;
    holdGain = mGain;
    modelWindow(cnt, tag);
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (i == 512)
        check(gainCode == 5'(holdGain), "R3",
              $sformatf("mid-window gain %0d expected %0d", gainCode, holdGain));
      if (gaps && (i % 4 == 0)) begin
        sampleValid = 1'b0; magBit = 1'b1;
        @(negedge clk);
      end
      sampleValid = 1'b1;
      magBit = (i < cnt);
    end
    @(negedge clk);
    sampleValid = 1'b0; magBit = 1'b0;
    -> winTick;
  endtask

  // Monitor: compare each window's outcome with the queued expectation
  initial begin
    forever begin
      @(winTick);
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "result with no expectation queued");
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(gainCode == 5'(it.gain) && busy == it.busy && locked == it.locked,
              it.tag,
              $sformatf("gain/busy/locked %0d/%0d/%0d expected %0d/%0d/%0d",
                        gainCode, busy, locked, it.gain, it.busy, it.locked));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(gainCode == 5'd16 && busy && !locked, "R1",
          $sformatf("reset gain/busy/locked %0d/%0d/%0d expected 16/1/0",
                    gainCode, busy, locked));
    rstN = 1'b1;
    @(negedge clk);
    runWindow(338,  1'b0, "R4");    // on target
    runWindow(370,  1'b0, "R4");    // upper band edge
    runWindow(371,  1'b0, "R5");    // just outside, from lock: R8
    runWindow(306,  1'b0, "R4");    // lower band edge
    runWindow(305,  1'b0, "R5");    // just outside below
    runWindow(0,    1'b0, "R6");    // large shortfall, step capped at 8
    runWindow(0,    1'b0, "R7");    // clamps at 31
    runWindow(0,    1'b0, "R7");    // stays at 31
    runWindow(467,  1'b0, "R6");    // error 129, step 4
    runWindow(466,  1'b0, "R5");    // error 128, single step
    runWindow(1024, 1'b0, "R6");    // full window, step 8
    runWindow(1024, 1'b0, "R6");
    runWindow(1024, 1'b0, "R7");
    runWindow(1024, 1'b0, "R7");    // clamps at 0
    runWindow(338,  1'b1, "R2");    // idle cycles with flag high ignored
    runWindow(700,  1'b0, "R8");    // abrupt change after lock
    runWindow(338,  1'b0, "R9");
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R3",
          $sformatf("pending expectations %0d expected 0", expQ.size()));
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R3: watchdog expired, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule